// File: doc/BRIEF.md
# Microcode Scratch Register File

This block is the register store of a microprogrammed processor. It keeps sixteen 16-bit registers. The lower eight, 0 to 7, are the registers a program can name. The upper eight, 8 to 15, are scratch space that only the microcode can reach. Four of the upper entries have fixed roles. Register 12 holds the source address, 13 the source data, 14 the destination address and 15 the destination data. In hardware they are ordinary storage. Register 0 is a constant zero.

The file has two address ports. The first port (DSA) names the register that is written and also the register read on the first read output. The second port (SB) names the register read on the second read output. Each port is steered by a 5-bit control field from the microinstruction. The top bit of the field chooses where the address comes from. When it is 0, the low four bits of the field are the address, so any of the sixteen registers can be reached. When it is 1, the address comes from the instruction register, and bit 3 of the field chooses its destination field or its source field. The 3-bit instruction field gets a leading zero, so this path reaches only registers 0 to 7. Because either port can pick either instruction field, the instruction's destination field can serve as a source and its source field as a destination.

Both reads are combinational. The single write takes effect on the rising clock edge.

Top module: `ucode_regfile`

## Requirements
- R1: A cycle with `rst` high clears registers 1 to 15 to zero at the next rising edge, and `rst` overrides a write in the same cycle. Once reset is released, every read returns zero until something is written.
- R2: When `wr_en` is high at a rising edge, `wr_data` is stored in the register named by the DSA port. When `wr_en` is low, no register changes.
- R3: Register 0 always reads as zero on both outputs. A write addressed to it is discarded.
- R4: A control field with bit 4 = 0 uses bits 3:0 as the register address, reaching all of registers 0 to 15 including the scratch registers 8 to 15.
- R5: A control field with bit 4 = 1 takes the address from the instruction register. Bit 3 = 0 selects `ir_dst` and bit 3 = 1 selects `ir_src`. The 3-bit value is zero-extended, so the address is always 0 to 7.
- R6: The SB port decodes its control field by the same rules, independently of the DSA port. It only reads.
- R7: A read of the register being written in the same cycle returns the value held before that edge.
- R8: The scratch registers 12, 13, 14 and 15 each hold a distinct value independently of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the write and the reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable for the DSA-addressed register |
| dsa_ctl | input | 5 | Address control for the write / first-read port |
| sb_ctl | input | 5 | Address control for the second-read port |
| ir_dst | input | 3 | Destination register field of the instruction register |
| ir_src | input | 3 | Source register field of the instruction register |
| wr_data | input | 16 | Data to be written |
| rd_dsa | output | 16 | Contents of the DSA-addressed register |
| rd_sb | output | 16 | Contents of the SB-addressed register |

## Verification
Embedded properties check five things on every cycle:
- Reset empties the store.
- An idle cycle leaves every register unchanged.
- An enabled write lands in the addressed entry.
- An address of zero reads as zero.
- The instruction-sourced path never produces an address above 7.

The bench's scenarios cover behaviour that needs known history:
- Whether bit 3 picks the destination field or the source field.
- That an instruction field of 7 reaches register 7 and not a scratch register.
- That a read in the same cycle as a write returns the old value.
- That the four scratch roles keep separate contents.
- That reset wins over a simultaneous write.

// File: rtl/ucrf_pkg.sv
package ucrf_pkg;

    localparam int RF_DATA_W  = 16;
    localparam int RF_DEPTH   = 16;
    localparam int RF_ADDR_W  = $clog2(RF_DEPTH);
    localparam int IR_FIELD_W = 3;
    localparam int RF_CTL_W   = RF_ADDR_W + 1;

    // fixed scratch roles
    localparam int SCR_SRC_ADDR = 12;
    localparam int SCR_SRC_DATA = 13;
    localparam int SCR_DST_ADDR = 14;
    localparam int SCR_DST_DATA = 15;

    typedef enum logic {
        FROM_MICRO = 1'b0,
        FROM_INSTR = 1'b1
    } addr_from_e;

    typedef enum logic {
        PICK_DST = 1'b0,
        PICK_SRC = 1'b1
    } ir_pick_e;

endpackage

// File: rtl/ucrf_addr_mux.sv
module ucrf_addr_mux #(
    parameter int ADDR_W = ucrf_pkg::RF_ADDR_W,
    parameter int IR_W   = ucrf_pkg::IR_FIELD_W,
    localparam int CTL_W = ADDR_W + 1,
    localparam int PAD_W = ADDR_W - IR_W
) (
    input  logic [CTL_W-1:0] ctl,
    input  logic [IR_W-1:0]  ir_dst,
    input  logic [IR_W-1:0]  ir_src,
    output logic [ADDR_W-1:0] addr
);
    import ucrf_pkg::*;

    addr_from_e      from_d;
    ir_pick_e        pick_d;
    logic [IR_W-1:0] ir_sel_d;

    always_comb begin
        from_d   = addr_from_e'(ctl[CTL_W-1]);
        pick_d   = ir_pick_e'(ctl[CTL_W-2]);
        ir_sel_d = (pick_d == PICK_SRC) ? ir_src : ir_dst;
        if (from_d == FROM_INSTR) begin
            addr = {{PAD_W{1'b0}}, ir_sel_d};
        end else begin
            addr = ctl[ADDR_W-1:0];
        end
    end

endmodule

// File: rtl/ucrf_store.sv
module ucrf_store #(
    parameter int DATA_W = ucrf_pkg::RF_DATA_W,
    parameter int DEPTH  = ucrf_pkg::RF_DEPTH,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    typedef struct packed {
        logic [DEPTH-1:1][DATA_W-1:0] regs;
    } store_t;

    store_t state_d, state_q;
    logic [DATA_W-1:0] view [DEPTH];

    // entry 0 has no storage: a constant zero
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_view
        if (gi == 0) begin : g_zero
            assign view[gi] = '0;
        end else begin : g_reg
            assign view[gi] = state_q.regs[gi];
        end
    end

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.regs = '0;
        end else if (we && (waddr != '0)) begin
            state_d.regs[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign rdata_a = view[raddr_a];
    assign rdata_b = view[raddr_b];

    // R1: reset empties every stored entry
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (state_q.regs == '0));

    // R2: no enable, no change
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(state_q.regs));

    // R2: an enabled write to a stored entry lands there
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && (waddr != '0)) |=> (view[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/ucode_regfile.sv
module ucode_regfile #(
    parameter int DATA_W = ucrf_pkg::RF_DATA_W,
    parameter int DEPTH  = ucrf_pkg::RF_DEPTH,
    parameter int IR_W   = ucrf_pkg::IR_FIELD_W,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CTL_W  = ADDR_W + 1,
    localparam int N_PORT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  dsa_ctl,
    input  logic [CTL_W-1:0]  sb_ctl,
    input  logic [IR_W-1:0]   ir_dst,
    input  logic [IR_W-1:0]   ir_src,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_dsa,
    output logic [DATA_W-1:0] rd_sb
);

    localparam int P_DSA = 0;
    localparam int P_SB  = 1;

    logic [N_PORT-1:0][CTL_W-1:0]  port_ctl;
    logic [N_PORT-1:0][ADDR_W-1:0] port_addr;

    assign port_ctl[P_DSA] = dsa_ctl;
    assign port_ctl[P_SB]  = sb_ctl;

    for (genvar gp = 0; gp < N_PORT; gp++) begin : g_port
        ucrf_addr_mux #(
            .ADDR_W (ADDR_W),
            .IR_W   (IR_W)
        ) u_mux (
            .ctl    (port_ctl[gp]),
            .ir_dst (ir_dst),
            .ir_src (ir_src),
            .addr   (port_addr[gp])
        );
    end

    ucrf_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .waddr   (port_addr[P_DSA]),
        .wdata   (wr_data),
        .raddr_a (port_addr[P_DSA]),
        .raddr_b (port_addr[P_SB]),
        .rdata_a (rd_dsa),
        .rdata_b (rd_sb)
    );

    // R3: address zero reads zero on both outputs
    a_r3_zero_dsa: assert property (@(posedge clk) disable iff (rst)
        (port_addr[P_DSA] == '0) |-> (rd_dsa == '0));
    a_r3_zero_sb: assert property (@(posedge clk) disable iff (rst)
        (port_addr[P_SB] == '0) |-> (rd_sb == '0));

    // R5 / R6: instruction-sourced addresses stay in the visible half
    a_r5_instr_visible: assert property (@(posedge clk) disable iff (rst)
        dsa_ctl[CTL_W-1] |-> (port_addr[P_DSA][ADDR_W-1:IR_W] == '0));
    a_r6_instr_visible_sb: assert property (@(posedge clk) disable iff (rst)
        sb_ctl[CTL_W-1] |-> (port_addr[P_SB][ADDR_W-1:IR_W] == '0));

endmodule

// File: tb/tb_ucode_regfile.sv
module tb_ucode_regfile;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [4:0]  dsa_ctl, sb_ctl;
    logic [2:0]  ir_dst, ir_src;
    logic [15:0] wr_data;
    logic [15:0] rd_dsa, rd_sb;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    ucode_regfile dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .dsa_ctl (dsa_ctl),
        .sb_ctl  (sb_ctl),
        .ir_dst  (ir_dst),
        .ir_src  (ir_src),
        .wr_data (wr_data),
        .rd_dsa  (rd_dsa),
        .rd_sb   (rd_sb)
    );

    // control codes: micro address a = {0,a}; instr DST = 5'h10; instr SRC = 5'h18
    localparam logic [4:0] C_DST = 5'h10;
    localparam logic [4:0] C_SRC = 5'h18;

    typedef struct packed {
        logic        we;
        logic [4:0]  dsa;
        logic [4:0]  sb;
        logic [2:0]  dst;
        logic [2:0]  src;
        logic [15:0] wd;
        logic [15:0] exp_a;
        logic [15:0] exp_b;
    } vec_t;

    localparam int NV = 17;
    // expectations are the read values before the edge of that row
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd1,  5'd0,  3'd0, 3'd0, 16'h1111, 16'h0000, 16'h0000}, // R1 post-reset zero, R2
        '{1'b1, 5'd12, 5'd1,  3'd0, 3'd0, 16'hC0C0, 16'h0000, 16'h1111}, // R8 reg12
        '{1'b1, 5'd13, 5'd12, 3'd0, 3'd0, 16'hD0D0, 16'h0000, 16'hC0C0}, // R8 reg13
        '{1'b1, 5'd14, 5'd13, 3'd0, 3'd0, 16'hE0E0, 16'h0000, 16'hD0D0}, // R8 reg14
        '{1'b1, 5'd15, 5'd14, 3'd0, 3'd0, 16'hF0F0, 16'h0000, 16'hE0E0}, // R8 reg15
        '{1'b0, 5'd15, 5'd12, 3'd0, 3'd0, 16'hDEAD, 16'hF0F0, 16'hC0C0}, // R8, R2 disabled write
        '{1'b0, 5'd15, 5'd15, 3'd0, 3'd0, 16'h0000, 16'hF0F0, 16'hF0F0}, // R2 DEAD not stored
        '{1'b1, C_DST, 5'd0,  3'd5, 3'd3, 16'h5555, 16'h0000, 16'h0000}, // R5 DST as destination
        '{1'b1, C_SRC, C_DST, 3'd5, 3'd3, 16'h3333, 16'h0000, 16'h5555}, // R5 SRC as dest, R6 DST as source
        '{1'b0, 5'd3,  C_SRC, 3'd0, 3'd5, 16'h0000, 16'h3333, 16'h5555}, // R6 SRC pick, R4
        '{1'b1, 5'd0,  5'd0,  3'd0, 3'd0, 16'hFFFF, 16'h0000, 16'h0000}, // R3 write to reg0
        '{1'b0, 5'd0,  5'd0,  3'd0, 3'd0, 16'h0000, 16'h0000, 16'h0000}, // R3 discarded
        '{1'b1, 5'd1,  5'd1,  3'd0, 3'd0, 16'hAAAA, 16'h1111, 16'h1111}, // R7 old value
        '{1'b0, 5'd1,  5'd1,  3'd0, 3'd0, 16'h0000, 16'hAAAA, 16'hAAAA}, // R2 new value
        '{1'b0, C_DST, 5'd15, 3'd7, 3'd0, 16'h0000, 16'h0000, 16'hF0F0}, // R5 zero-extend: 7 not 15
        '{1'b1, 5'd8,  5'd0,  3'd0, 3'd0, 16'h8888, 16'h0000, 16'h0000}, // R4 micro reaches 8
        '{1'b0, 5'd0,  5'd8,  3'd0, 3'd0, 16'h0000, 16'h0000, 16'h8888}  // R4 bit3 is address bit
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic [4:0] d, input logic [4:0] s,
                         input logic [2:0] id, input logic [2:0] is, input logic [15:0] wd);
        @(negedge clk);
        wr_en = we; dsa_ctl = d; sb_ctl = s; ir_dst = id; ir_src = is; wr_data = wd;
        #1;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; dsa_ctl = '0; sb_ctl = '0;
        ir_dst = '0; ir_src = '0; wr_data = '0;
        @(posedge clk);
        @(posedge clk);
        drive(1'b0, 5'd5, 5'd9, 3'd0, 3'd0, 16'h0);
        chk("R1 reset dsa", rd_dsa, 16'h0000);
        chk("R1 reset sb", rd_sb, 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].we, VECS[i].dsa, VECS[i].sb, VECS[i].dst, VECS[i].src, VECS[i].wd);
            chk($sformatf("vector %0d port A", i), rd_dsa, VECS[i].exp_a);
            chk($sformatf("vector %0d port B", i), rd_sb, VECS[i].exp_b);
        end

        // R1: reset mid-run beats a simultaneous write
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; dsa_ctl = 5'd1; wr_data = 16'h7777;
        drive(1'b0, 5'd1, 5'd15, 3'd0, 3'd0, 16'h0);
        rst = 1'b0;
        chk("R1 reg1 cleared", rd_dsa, 16'h0000);
        chk("R1 reg15 cleared", rd_sb, 16'h0000);
        drive(1'b0, 5'd8, 5'd12, 3'd0, 3'd0, 16'h0);
        chk("R1 reg8 cleared", rd_dsa, 16'h0000);
        chk("R1 reg12 cleared", rd_sb, 16'h0000);

        // R5: SRC field 7 writes reg7; R4 micro reads reg15 untouched
        drive(1'b1, C_SRC, 5'd15, 3'd0, 3'd7, 16'h7A7A);
        drive(1'b0, 5'd7, 5'd15, 3'd0, 3'd0, 16'h0);
        chk("R5 reg7 via SRC", rd_dsa, 16'h7A7A);
        chk("R5 reg15 untouched", rd_sb, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule